// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a RISC core and a data memory that is one 32-bit word wide. Each request carries the byte address, the access size, a direction bit and a signed/unsigned flag. A store request also carries the register value, and a load request carries the word that memory returned. The block answers each request with:

- the word-aligned memory address;
- a per-lane write-enable mask;
- write data already placed on the byte lanes the store will touch;
- for a load, the 32-bit register value, sign- or zero-extended from the addressed byte or halfword;
- a flag that marks the access as misaligned.

Bytes are numbered big-endian. The lowest address in a word holds its most significant byte.

Requests enter on a valid/ready channel and responses leave on a second valid/ready channel, with one register stage between them. The request side is ready whenever the output register is empty or is being drained in the same cycle. While the consumer holds `rsp_ready` low, the response is frozen. No request is lost and none is reordered. Address generation, the memory itself and any exception handling beyond the flag are outside the block.

Size encoding on `req_size`: `00` byte, `01` halfword, `10` word, `11` reserved.

Top module: `be_lane_unit`

## Requirements
- R1: After reset `rsp_valid` is low and `req_ready` is high.
- R2: `rsp_addr` equals the request address with its two least significant bits forced to zero, for every size and direction.
- R3: A byte store at offset k (the address bits 1:0) sets only mask bit 3-k, where mask bit i enables memory bits 8i+7:8i. `rsp_wdata` carries the source register's bits 7:0 on all four lanes.
- R4: A halfword store at offset 0 yields mask `1100` and at offset 2 yields mask `0011`. `rsp_wdata` carries the source bits 15:0 in both halves.
- R5: An aligned word store yields mask `1111` and `rsp_wdata` equal to the source register.
- R6: `rsp_misaligned` is set for a halfword with address bit 0 set, for a word whose address bits 1:0 are nonzero, and for the reserved size code. When it is set, the mask is `0000` and a load returns zero.
- R7: A signed byte load takes memory bits 31-8k:24-8k for offset k, and a signed halfword load takes bits 31:16 (offset 0) or 15:0 (offset 2). The result is sign-extended to 32 bits by copying the top loaded bit.
- R8: Unsigned byte and halfword loads select the same lanes as R7 and fill the upper bits with zeros.
- R9: A load never asserts any mask bit. An aligned word load returns the memory word unchanged.
- R10: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. A response stays valid and unchanged while `rsp_ready` is low. Each accepted request yields exactly one response, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Load sign-extends when 1, zero-extends when 0 |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store source register value |
| req_mdata | input | 32 | Memory word read for a load |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Word-aligned memory address |
| rsp_mask | output | 4 | Byte-lane write enables (bit i covers bits 8i+7:8i) |
| rsp_wdata | output | 32 | Lane-placed store data |
| rsp_ldata | output | 32 | Extended load result (zero for stores) |
| rsp_misaligned | output | 1 | Access violates its alignment rule |

## Verification
The assertions assume that `rsp_ready` may change in any cycle, and that the request fields need to be meaningful only in a cycle where `req_valid` and `req_ready` are both high. Under those assumptions they check the hold-under-backpressure rule and the gating of the write mask whenever the misalignment flag is set.

The stimulus follows the same rules:
- It changes the request fields only away from the clock edge.
- It drops `req_valid` as soon as a request is taken.
- It pulls `rsp_ready` low on a fixed repeating pattern, so stalls occur both right after and well after a request is accepted.
- It sweeps every size code, including the reserved one, against every address offset, in both directions and for both extension flags.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             misaligned
);
  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = off[0];
      SZ_WORD: misaligned = (off != '0);
      default: misaligned = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
#(
  parameter int NLANE = 4,
  localparam int OFF_W = $clog2(NLANE),
  localparam int DATA_W = 8 * NLANE
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] src,
  output logic [NLANE-1:0]  mask,
  output logic [DATA_W-1:0] data
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    // Byte offset that lands on this lane in big-endian order.
    localparam logic [OFF_W-1:0] BOFF = OFF_W'(NLANE - 1 - i);
    logic       hit;
    logic [7:0] lane_b;

    always_comb begin
      hit    = 1'b0;
      lane_b = src[8*i +: 8];
      case (size)
        SZ_BYTE: begin
          hit    = (off == BOFF);
          lane_b = src[7:0];
        end
        SZ_HALF: begin
          hit    = (off[OFF_W-1:1] == BOFF[OFF_W-1:1]);
          lane_b = BOFF[0] ? src[7:0] : src[15:8];
        end
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end

    assign mask[i]         = hit & ~misaligned;
    assign data[8*i +: 8]  = lane_b;
  end
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
  import lsu_lane_pkg::*;
#(
  parameter int NLANE = 4,
  localparam int OFF_W = $clog2(NLANE),
  localparam int DATA_W = 8 * NLANE
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              sext,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] mdata,
  output logic [DATA_W-1:0] value
);
  logic [OFF_W-1:0] byte_lane;
  logic [OFF_W-1:0] half_lane;
  logic [7:0]       byte_v;
  logic [15:0]      half_v;

  // Offset k maps to lane NLANE-1-k; a halfword starts on its even low lane.
  assign byte_lane = ~off;
  assign half_lane = {~off[OFF_W-1:1], 1'b0};
  assign byte_v    = mdata[{byte_lane, 3'b000} +: 8];
  assign half_v    = mdata[{half_lane, 3'b000} +: 16];

  always_comb begin
    value = '0;
    if (!misaligned) begin
      case (size)
        SZ_BYTE: value = {{(DATA_W-8){sext & byte_v[7]}}, byte_v};
        SZ_HALF: value = {{(DATA_W-16){sext & half_v[15]}}, half_v};
        SZ_WORD: value = mdata;
        default: value = '0;
      endcase
    end
  end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NLANE = 4,
  localparam int DATA_W = 8 * NLANE,
  localparam int OFF_W = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_mdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [NLANE-1:0]  rsp_mask,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] rsp_ldata,
  output logic              rsp_misaligned
);
  acc_size_e         size;
  logic [OFF_W-1:0]  off;
  logic              mis;
  logic [NLANE-1:0]  st_mask;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] ld_value;
  logic              accept;

  assign size   = acc_size_e'(req_size);
  assign off    = req_addr[OFF_W-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept = req_valid && req_ready;

  lsu_align_check #(.OFF_W(OFF_W)) u_align (
    .size       (size),
    .off        (off),
    .misaligned (mis)
  );

  lsu_store_lanes #(.NLANE(NLANE)) u_store (
    .size       (size),
    .off        (off),
    .misaligned (mis),
    .src        (req_wdata),
    .mask       (st_mask),
    .data       (st_data)
  );

  lsu_load_lanes #(.NLANE(NLANE)) u_load (
    .size       (size),
    .off        (off),
    .sext       (req_signed),
    .misaligned (mis),
    .mdata      (req_mdata),
    .value      (ld_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_addr       <= '0;
      rsp_mask       <= '0;
      rsp_wdata      <= '0;
      rsp_ldata      <= '0;
      rsp_misaligned <= 1'b0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_addr       <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      rsp_mask       <= req_store ? st_mask : '0;
      rsp_wdata      <= st_data;
      rsp_ldata      <= req_store ? '0 : ld_value;
      rsp_misaligned <= mis;
    end else if (rsp_ready) begin
      rsp_valid      <= 1'b0;
    end
  end

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);  // R10
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);  // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_mask)
      && $stable(rsp_wdata) && $stable(rsp_ldata) && $stable(rsp_misaligned));  // R10
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misaligned |-> rsp_mask == '0);  // R6
  AST_WORD_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[OFF_W-1:0] == '0);  // R2
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_mask) <= 2) || (rsp_mask == {NLANE{1'b1}}));  // R4
endmodule

// File: tb/be_lane_unit_tb.sv
`timescale 1ns/100ps
module be_lane_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_mdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [3:0]  rsp_mask;
  logic [31:0] rsp_wdata;
  logic [31:0] rsp_ldata;
  logic        rsp_misaligned;

  always #2 clk = ~clk;

  be_lane_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mdata(req_mdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_mask(rsp_mask), .rsp_wdata(rsp_wdata), .rsp_ldata(rsp_ldata),
    .rsp_misaligned(rsp_misaligned)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        sg;
    logic [31:0] addr;
    logic [3:0]  mask;
    logic [31:0] wdata;
    logic [31:0] ldata;
    logic        mis;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic st, input logic [1:0] sz, input logic sg,
                                 input logic [31:0] a, input logic [31:0] wd,
                                 input logic [31:0] md);
    exp_t e;
    logic [7:0]  b;
    logic [15:0] h;
    e.st = st; e.sz = sz; e.sg = sg;
    e.addr = {a[31:2], 2'b00};
    e.mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
    e.mask = 4'b0000;
    e.ldata = 32'd0;
    case (sz)
      2'd0: e.wdata = {4{wd[7:0]}};
      2'd1: e.wdata = {2{wd[15:0]}};
      default: e.wdata = wd;
    endcase
    case (a[1:0])
      2'd0: b = md[31:24];
      2'd1: b = md[23:16];
      2'd2: b = md[15:8];
      default: b = md[7:0];
    endcase
    h = a[1] ? md[15:0] : md[31:16];
    if (st && !e.mis) begin
      case (sz)
        2'd0: e.mask = 4'b1000 >> a[1:0];
        2'd1: e.mask = a[1] ? 4'b0011 : 4'b1100;
        default: e.mask = 4'b1111;
      endcase
    end
    if (!st && !e.mis) begin
      case (sz)
        2'd0: e.ldata = sg ? {{24{b[7]}}, b} : {24'd0, b};
        2'd1: e.ldata = sg ? {{16{h[15]}}, h} : {16'd0, h};
        default: e.ldata = md;
      endcase
    end
    return e;
  endfunction

  task automatic send(input logic st, input logic [1:0] sz, input logic sg,
                      input logic [31:0] a, input logic [31:0] wd, input logic [31:0] md);
    @(negedge clk);
    req_store = st; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd; req_mdata = md; req_valid = 1'b1;
    #0.5;
    while (!req_ready) begin
      @(negedge clk);
      #0.5;
    end
    exp_q.push_back(model(st, sz, sg, a, wd, md));
    @(posedge clk);
    #0.1;
    req_valid = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Back-pressure pattern on the response side.
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    rsp_ready = !((cyc % 7 == 2) || (cyc % 7 == 3) || (cyc % 11 == 5));
  end

  // Monitor / scoreboard.
  logic        stalled = 1'b0;
  logic [31:0] hold_addr, hold_wdata, hold_ldata;
  logic [3:0]  hold_mask;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (stalled) begin
          check(rsp_valid, "R10 response dropped during stall", 32'(rsp_valid), 32'd1);
          check(rsp_addr == hold_addr && rsp_mask == hold_mask && rsp_wdata == hold_wdata
                && rsp_ldata == hold_ldata, "R10 response changed during stall",
                rsp_ldata, hold_ldata);
        end
        stalled = rsp_valid && !rsp_ready;
        hold_addr = rsp_addr; hold_mask = rsp_mask;
        hold_wdata = rsp_wdata; hold_ldata = rsp_ldata;
        check(req_ready == (!rsp_valid || rsp_ready), "R10 ready rule",
              32'(req_ready), 32'(!rsp_valid || rsp_ready));
        if (rsp_valid && rsp_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10 response without request", 32'd1, 32'd0);
          end else begin
            exp_t e;
            string mtag;
            string wtag;
            string ltag;
            e = exp_q.pop_front();
            check(rsp_misaligned == e.mis, "R6 misaligned flag", 32'(rsp_misaligned), 32'(e.mis));
            check(rsp_addr == e.addr, "R2 word address", rsp_addr, e.addr);
            if (!e.st) mtag = "R9 load mask";
            else if (e.mis) mtag = "R6 mask gated";
            else if (e.sz == 2'd0) mtag = "R3 byte mask";
            else if (e.sz == 2'd1) mtag = "R4 half mask";
            else mtag = "R5 word mask";
            check(rsp_mask == e.mask, mtag, 32'(rsp_mask), 32'(e.mask));
            if (e.st) begin
              if (e.sz == 2'd0) wtag = "R3 byte lane data";
              else if (e.sz == 2'd1) wtag = "R4 half lane data";
              else wtag = "R5 word data";
              check(rsp_wdata == e.wdata, wtag, rsp_wdata, e.wdata);
            end else begin
              if (e.mis) ltag = "R6 misaligned load zero";
              else if (e.sz == 2'd2) ltag = "R9 word load";
              else if (e.sg) ltag = "R7 signed load";
              else ltag = "R8 unsigned load";
              check(rsp_ldata == e.ldata, ltag, rsp_ldata, e.ldata);
            end
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #(4 * 150000);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_up();
    end
  end

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #0.1;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!rsp_valid, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(req_ready, "R1 req_ready after reset", 32'(req_ready), 32'd1);

    // Directed sweep: every direction, size, offset and extension flag.
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int sg = 0; sg < 2; sg++) begin
            logic [31:0] md;
            md = sg ? 32'h80FF_7F01 : 32'h7F01_80FF;
            send(st[0], sz[1:0], sg[0], 32'h0000_1000 | off, 32'hA5C3_96E1 ^ (off << 8), md);
          end

    // Pseudo-random mix.
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, wd, md;
      seed = nxt(seed); a  = seed;
      seed = nxt(seed); wd = seed;
      seed = nxt(seed); md = seed;
      seed = nxt(seed);
      send(seed[31], seed[29:28], seed[27], a, wd, md);
    end

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    check(exp_q.size() == 0, "R10 all responses delivered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    finish_up();
  end
endmodule